// File: doc/BRIEF.md
# Presettable Down Counter with Snapshot Byte Readout

This block is a 16-bit synchronous down counter that a host reaches over an 8-bit data bus. The host loads a preset as two byte writes. The counter takes that preset on the next count-enable cycle and then decrements once per enabled cycle. When it reaches one, it reloads the preset and drives its output low for one clock, so it acts as a rate generator.

The count register cannot be read directly. Reads go through a pair of byte-wide output latches. These follow the live count until the host issues a latch command. The latches then hold a snapshot until both bytes have been read. A second command captures a status byte. That byte holds the output level, a null-count flag and the stored control field, and it takes priority on the next read.

Two small state machines run the block. The preset loader has states `LD_WAIT_LO` and `LD_WAIT_HI`:
- A data write moves it from `LD_WAIT_LO` to `LD_WAIT_HI`.
- A second data write moves it back to `LD_WAIT_LO` and commits the preset.
- A control write returns it to `LD_WAIT_LO` from either state.

The readout sequencer has states `RD_LIVE_LO`, `RD_LIVE_HI`, `RD_HELD_LO` and `RD_HELD_HI`:
- A count read steps LIVE_LO to LIVE_HI, LIVE_HI to LIVE_LO, HELD_LO to HELD_HI, and HELD_HI to LIVE_LO.
- A count-latch command from either live state enters HELD_LO.
- A read while a status byte is pending returns the status and leaves the state unchanged.

Top module: `snap_down_counter`

## Requirements
- R1: After reset, out_pin is 1, the count reads 0 as two bytes, and a status read returns 8'h80 (out 1, null count 0, control field 0).
- R2: Data writes (addr 0) take the preset low byte first, then the high byte. The null-count flag (status bit 6) is 1 from the high-byte write until the preset is transferred into the counter on the next cycle with cnt_en high.
- R3: Once loaded, the counter decrements by one on each cycle with cnt_en high and holds its value on cycles with cnt_en low.
- R4: On an enabled cycle with count equal to 1, the counter reloads the preset and out_pin is 0 for exactly the following clock; otherwise out_pin is 1.
- R5: With no snapshot pending, reads at addr 0 return the live count: low byte first, then high byte.
- R6: Writing a command byte (addr 1) with bit 7 = 0 and bit 0 = 1 freezes a snapshot of the count. The next two reads return its low byte and then its high byte, and later reads follow the live count again.
- R7: A count-latch command while a snapshot is pending is ignored; the earlier snapshot is returned.
- R8: A command byte with bit 7 = 0 and bit 1 = 1 captures a status byte: {out_pin, null count, control[5:0]}. While a status byte is pending, the next read returns it before any count byte, and further status latches are ignored.
- R9: A command byte with bit 7 = 1 stores bits 5:0 as the control field and restarts the preset byte sequence at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable, one decrement per enabled cycle |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (must not coincide with wr_en) |
| addr | input | 1 | 0 selects count data, 1 selects the command register |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte, valid during the read cycle |
| out_pin | output | 1 | Rate-generator output, low for one clock per period |

## Verification
The main function is exercised with several preset patterns:
- A small preset run with continuous enable shows the decrement-and-reload period.
- A preset with a non-zero high byte, run with enable gaps, separates decrementing from holding and confirms that byte order is honoured.

Reads interleaved with counting tell live tracking apart from a frozen snapshot. A repeated latch in the middle of a pair shows whether a pending snapshot is overwritten. Combined status and count latches distinguish the read priority. A control write between preset bytes shows whether the loader's byte pointer is reset.

// File: rtl/snap_counter_pkg.sv
package snap_counter_pkg;
    typedef enum logic {
        LD_WAIT_LO = 1'b0,
        LD_WAIT_HI = 1'b1
    } ld_state_e;

    typedef enum logic [1:0] {
        RD_LIVE_LO = 2'b00,
        RD_LIVE_HI = 2'b01,
        RD_HELD_LO = 2'b10,
        RD_HELD_HI = 2'b11
    } rd_state_e;
endpackage

// File: rtl/snap_preset_loader.sv
module snap_preset_loader
    import snap_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_wr,
    input  logic                 ctrl_wr,
    input  logic [CNT_W/2-1:0]   wr_byte,
    input  logic                 take,
    output logic [CNT_W-1:0]     preset,
    output logic                 load_pend
);
    localparam int BYTE_W = CNT_W / 2;

    ld_state_e           state_q, state_d;
    logic [BYTE_W-1:0]   lo_q;
    logic [CNT_W-1:0]    preset_q;
    logic                pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_WAIT_LO: if (ctrl_wr) state_d = LD_WAIT_LO;
                        else if (data_wr) state_d = LD_WAIT_HI;
            LD_WAIT_HI: if (ctrl_wr || data_wr) state_d = LD_WAIT_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_WAIT_LO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q     <= '0;
            preset_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (data_wr && state_q == LD_WAIT_LO) lo_q <= wr_byte;
            if (data_wr && state_q == LD_WAIT_HI) begin
                preset_q <= {wr_byte, lo_q};
                pend_q   <= 1'b1;
            end else if (take) begin
                pend_q   <= 1'b0;
            end
        end
    end

    assign preset    = preset_q;
    assign load_pend = pend_q;

    // R2
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take) |=> pend_q);
endmodule

// File: rtl/snap_count_core.sv
module snap_count_core #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              load_pend,
    input  logic [CNT_W-1:0]  preset,
    output logic              take,
    output logic [CNT_W-1:0]  count,
    output logic              out_pin
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             armed_q;
    logic             out_q;
    logic             terminal;

    assign take     = cnt_en && load_pend;
    assign terminal = cnt_en && !load_pend && armed_q && (count_q == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            armed_q <= 1'b0;
            out_q   <= 1'b1;
        end else begin
            out_q <= !terminal;
            if (take) begin
                count_q <= preset;
                armed_q <= 1'b1;
            end else if (cnt_en && armed_q) begin
                if (count_q == ONE) count_q <= preset;
                else                count_q <= count_q - ONE;
            end
        end
    end

    assign count   = count_q;
    assign out_pin = out_q;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !load_pend && armed_q && count_q != ONE) |=> (count_q == $past(count_q) - ONE));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count_q));

    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> ($past(count_q) == ONE));
endmodule

// File: rtl/snap_readout.sv
module snap_readout
    import snap_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    count,
    input  logic [CNT_W/2-1:0]  status_now,
    input  logic                latch_cnt,
    input  logic                latch_st,
    input  logic                rd_fire,
    output logic [CNT_W/2-1:0]  rd_byte
);
    localparam int BYTE_W = CNT_W / 2;

    rd_state_e          state_q, state_d;
    logic [CNT_W-1:0]   ol_q;
    logic [BYTE_W-1:0]  st_q;
    logic               st_pend_q;
    logic               held;
    logic               live;
    logic [CNT_W-1:0]   view;

    assign held = (state_q == RD_HELD_LO) || (state_q == RD_HELD_HI);
    assign live = !held;

    always_comb begin
        state_d = state_q;
        if (rd_fire && !st_pend_q) begin
            unique case (state_q)
                RD_LIVE_LO: state_d = RD_LIVE_HI;
                RD_LIVE_HI: state_d = RD_LIVE_LO;
                RD_HELD_LO: state_d = RD_HELD_HI;
                RD_HELD_HI: state_d = RD_LIVE_LO;
            endcase
        end else if (latch_cnt && live) begin
            state_d = RD_HELD_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_LIVE_LO;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ol_q      <= '0;
            st_q      <= '0;
            st_pend_q <= 1'b0;
        end else begin
            if (latch_cnt && live) ol_q <= count;
            if (latch_st && !st_pend_q) begin
                st_q      <= status_now;
                st_pend_q <= 1'b1;
            end else if (rd_fire && st_pend_q) begin
                st_pend_q <= 1'b0;
            end
        end
    end

    assign view = held ? ol_q : count;

    always_comb begin
        if (st_pend_q)                                          rd_byte = st_q;
        else if (state_q == RD_LIVE_HI || state_q == RD_HELD_HI) rd_byte = view[CNT_W-1:BYTE_W];
        else                                                    rd_byte = view[BYTE_W-1:0];
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(ol_q));

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_pend_q && !rd_fire) |=> (st_pend_q && $stable(st_q)));
endmodule

// File: rtl/snap_down_counter.sv
module snap_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 addr,
    input  logic [CNT_W/2-1:0]   wr_data,
    output logic [CNT_W/2-1:0]   rd_data,
    output logic                 out_pin
);
    localparam int BYTE_W = CNT_W / 2;
    localparam int CTRL_W = BYTE_W - 2;

    logic               data_wr, cmd_wr, ctrl_wr, latch_cnt, latch_st, rd_fire;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [CNT_W-1:0]   preset, count;
    logic               load_pend, take, out_w;
    logic [BYTE_W-1:0]  status_now;

    assign data_wr   = wr_en && !addr;
    assign cmd_wr    = wr_en && addr;
    assign ctrl_wr   = cmd_wr && wr_data[BYTE_W-1];
    assign latch_cnt = cmd_wr && !wr_data[BYTE_W-1] && wr_data[0];
    assign latch_st  = cmd_wr && !wr_data[BYTE_W-1] && wr_data[1];
    assign rd_fire   = rd_en && !addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
    end

    assign status_now = {out_w, load_pend, ctrl_q};

    snap_preset_loader #(.CNT_W(CNT_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .wr_byte(wr_data), .take(take), .preset(preset), .load_pend(load_pend)
    );

    snap_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_pend(load_pend),
        .preset(preset), .take(take), .count(count), .out_pin(out_w)
    );

    snap_readout #(.CNT_W(CNT_W)) u_readout (
        .clk(clk), .rst_n(rst_n), .count(count), .status_now(status_now),
        .latch_cnt(latch_cnt), .latch_st(latch_st), .rd_fire(rd_fire),
        .rd_byte(rd_data)
    );

    assign out_pin = out_w;

    // R9
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_q == $past(wr_data[CTRL_W-1:0])));
endmodule

// File: tb/snap_down_counter_test.sv
module snap_down_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    snap_down_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .out_pin(out_pin)
    );

    // behavioural reference state
    logic [15:0] m_count = 0, m_preset = 0, m_ol = 0;
    logic [7:0]  m_lo = 0, m_stval = 0;
    logic [5:0]  m_ctrl = 0;
    bit m_wrhi = 0, m_pend = 0, m_armed = 0, m_out = 1;
    bit m_frozen = 0, m_rdhi = 0, m_stpend = 0;

    function automatic logic [7:0] exp_byte();
        logic [15:0] v;
        if (m_stpend) return m_stval;
        v = m_frozen ? m_ol : m_count;
        return m_rdhi ? v[15:8] : v[7:0];
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit d_wr, c_wr, l_cnt, l_st, r_f, tk, term, hi_wr;
        logic [15:0] old_count, old_preset;
        d_wr  = wr_en && !addr;
        c_wr  = wr_en && addr && wr_data[7];
        l_cnt = wr_en && addr && !wr_data[7] && wr_data[0];
        l_st  = wr_en && addr && !wr_data[7] && wr_data[1];
        r_f   = rd_en && !addr;
        old_count = m_count; old_preset = m_preset;
        // readout
        if (r_f) begin
            if (m_stpend) m_stpend = 0;
            else if (m_rdhi) begin m_rdhi = 0; m_frozen = 0; end
            else m_rdhi = 1;
        end else if (l_cnt && !m_frozen) begin
            m_ol = old_count; m_frozen = 1; m_rdhi = 0;
        end
        if (l_st && !m_stpend) begin
            m_stval = {m_out, m_pend, m_ctrl}; m_stpend = 1;
        end
        // counter
        tk   = cnt_en && m_pend;
        term = cnt_en && !m_pend && m_armed && old_count == 16'd1;
        if (tk) begin m_count = old_preset; m_armed = 1; end
        else if (cnt_en && m_armed) m_count = (old_count == 16'd1) ? old_preset : old_count - 16'd1;
        m_out = !term;
        // loader
        hi_wr = d_wr && m_wrhi;
        if (hi_wr) begin m_preset = {wr_data, m_lo}; m_wrhi = 0; m_pend = 1; end
        else begin
            if (tk) m_pend = 0;
            if (d_wr) begin m_lo = wr_data; m_wrhi = 1; end
        end
        if (c_wr) begin m_wrhi = 0; m_ctrl = wr_data[5:0]; end
    endtask

    // one bus cycle: drive at negedge, compare before posedge, advance model
    task automatic cyc(bit en, bit wr, bit rd, bit a, logic [7:0] d, string tag);
        cnt_en = en; wr_en = wr; rd_en = rd; addr = a; wr_data = d;
        #2;
        check("R4 out_pin", {7'b0, out_pin}, {7'b0, m_out});
        if (rd && !a) check(tag, rd_data, exp_byte());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(bit en, string tag);
        cyc(en, 0, 0, 0, 8'h00, tag);
    endtask
    task automatic rd(bit en, string tag);
        cyc(en, 0, 1, 0, 8'h00, tag);
    endtask
    task automatic wdat(logic [7:0] d, string tag);
        cyc(0, 1, 0, 0, d, tag);
    endtask
    task automatic wcmd(logic [7:0] d, string tag);
        cyc(0, 1, 0, 1, d, tag);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out reset", {7'b0, out_pin}, 8'h01);
        rd(0, "R1 count lo"); rd(0, "R1 count hi");
        wcmd(8'h02, "R1"); check("R1 status value", rd_data, 8'h80); rd(0, "R1 status");
        // R9 control word
        wcmd(8'h85, "R9");
        wcmd(8'h02, "R9"); check("R9 status ctrl", rd_data, 8'h85); rd(0, "R9 status read");
        // R2 preset and null count
        wdat(8'h05, "R2"); wdat(8'h00, "R2");
        wcmd(8'h02, "R2"); check("R2 null set", rd_data, 8'hC5); rd(0, "R2 null status");
        idle(1, "R2 transfer");
        wcmd(8'h02, "R2"); check("R2 null clear", rd_data, 8'h85); rd(0, "R2 status clear");
        // R3/R4/R5 continuous counting with live reads
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 0) rd(1, "R5 live lo");
            else if (i % 4 == 1) rd(1, "R5 live hi");
            else idle(i % 3 != 0, "R3");
        end
        // R6 snapshot, R7 ignored re-latch
        wcmd(8'h01, "R6");
        idle(1, "R6"); idle(1, "R6");
        rd(1, "R6 snap lo");
        wcmd(8'h01, "R7");
        idle(1, "R7"); idle(1, "R7");
        rd(1, "R7 snap hi kept");
        rd(0, "R6 live after release lo");
        rd(0, "R6 live after release hi");
        // R8 both latches, status first
        wcmd(8'h03, "R8");
        idle(1, "R8");
        wcmd(8'h02, "R8");
        rd(1, "R8 status first");
        rd(1, "R8 snap lo"); rd(1, "R8 snap hi");
        // R9 control write restarts preset sequence; preset 0x0102
        wdat(8'h34, "R9");
        wcmd(8'hAA, "R9");
        wdat(8'h02, "R9"); wdat(8'h01, "R9");
        for (int i = 0; i < 700; i++) begin
            if (i % 50 == 10) rd(1, "R5 live lo big");
            else if (i % 50 == 11) rd(1, "R5 live hi big");
            else if (i % 90 == 20) wcmd(8'h01, "R6 big");
            else if (i % 90 == 21) rd(1, "R6 big lo");
            else if (i % 90 == 22) rd(0, "R6 big hi");
            else idle(i % 5 != 0, "R3 R4");
        end
        wcmd(8'h02, "R8"); rd(0, "R8 final status");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule